// File: doc/BRIEF.md
# UART Autobaud Sync and Acknowledge Unit

The unit calibrates a UART link whose rate is not known in advance. After a `start` pulse it watches the idle-high receive line and waits for the remote side to send one sync byte, 0xAA. It times the low and high stretches of that byte in system clocks and turns them into a bit period. If the timing is consistent, it loads that period into the divisor output and raises `locked`. It then sends the two ASCII bytes "OK" (0x4F, then 0x4B) on the transmit line at the rate it measured.

Once the second acknowledge byte has left the line, `ready` goes high. This tells the surrounding logic that the remote side may now send its payload. If the line stays quiet for too long, the unit gives up and raises `timeout`.

The receive line passes through a two-flop synchronizer. This adds the same latency to every edge, so it does not change the spacing between edges.

Top module: `autobaud_ack`

## Requirements
- R1: After reset, `txLine` is high, `locked`, `ready` and `timeout` are low, and `divisor` is 0.
- R2: A `start` pulse arms the unit. The next falling edge on `rxLine` starts a measurement that collects seven edge-to-edge segments. For 0xAA sent 8N1 least significant bit first, these span exactly eight bit times, ending at the rising edge that begins bit 7. The candidate divisor is (sum of the seven segments + 4) >> 3. If the candidate is accepted, it appears on `divisor` and `locked` rises.
- R3: Let avg be the candidate and q = avg >> 2. The candidate is accepted only if both conditions hold:
  - each of the six single-bit segments lies within [avg − q, avg + q];
  - the first low segment (start bit plus bit 0, two bit times) lies within [2·avg − (avg >> 1), 2·avg + (avg >> 1)].
  Otherwise the measurement is dropped, `locked` stays low, and the unit re-arms on the next falling edge without a new `start`.
- R4: Segments with jitter that stay inside the R3 window produce the rounded mean as the divisor, not any single segment.
- R5: After lock, `txLine` sends 0x4F and then 0x4B back to back. Each frame is a low start bit, eight data bits least significant bit first, and one high stop bit. Every bit lasts exactly `divisor` clock cycles.
- R6: `ready` rises only after the stop bit of the second acknowledge byte has lasted its full `divisor` cycles. `ready` is never high while `locked` is low.
- R7: While the unit is armed or measuring, TMO_CYCLES clocks with no edge on `rxLine` set `timeout` and return the unit to idle. Idle means no lock, no transmission, and further receive traffic is ignored until the next `start`. `locked` and `timeout` are never high together.
- R8: A `start` pulse clears `locked`, `ready` and `timeout` on the next clock edge and re-arms the measurement.
- R9: After lock, receive traffic is ignored:
  - `divisor` holds its value while `locked` is high;
  - no frames are sent beyond the two acknowledge bytes.
- R10: Before the first `start`, traffic on `rxLine` produces no lock and no transmission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that arms or re-arms calibration |
| rxLine | input | 1 | Idle-high serial receive line |
| txLine | output | 1 | Idle-high serial transmit line carrying the acknowledge |
| divisor | output | CNT_W | Measured bit period in clock cycles |
| locked | output | 1 | Measurement accepted and divisor valid |
| ready | output | 1 | Acknowledge fully sent; payload may follow |
| timeout | output | 1 | No receive edge within the timeout window |

## Verification
The bench covers three kinds of bad sync timing:
- A single stretched one-bit segment. A design that skips the window check locks at a wrong rate.
- A 0x55 byte, whose first low segment is one bit long instead of two. A design that ignores the two-bit start segment accepts it and settles about 12% fast.
- Jittered segments that stay inside the window. A design that takes a single segment instead of the mean reports the jittered length.

The bench also checks four behaviours:
- Recovery after a rejected byte with no new `start`, and timeouts both before the first edge and partway through a byte.
- Transmitted bytes are sampled at mid-bit. This catches a wrong divisor, swapped acknowledge order or bit order, and a missing stop bit.
- The moment `ready` rises is checked against the end of the second stop bit. This catches a one-cycle-early release.
- Receive traffic sent during and after the acknowledge must not disturb the divisor or add frames.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  // Number of edge-to-edge segments timed in the sync byte, and the
  // power of two of bit times they span (start fall to bit-7 rise).
  localparam int SEG_COUNT  = 7;
  localparam int SPAN_SHIFT = 3;

  localparam int FRAME_BITS = 10;
  localparam logic [7:0] ACK_FIRST  = 8'h4F;
  localparam logic [7:0] ACK_SECOND = 8'h4B;

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_MEAS, S_CHECK, S_LOAD0, S_TX0, S_TX1, S_DONE
  } abState_t;

  typedef struct packed {
    logic startMeas;   // first falling edge seen: clear the accumulators
    logic captureSeg;  // edge seen while measuring: bank the segment
    logic loadDiv;     // measurement accepted: load the divisor
    logic loadByte;    // begin an acknowledge frame
    logic byteSel;     // 0: first ack byte, 1: second ack byte
    logic tmoRun;      // timeout counter enabled
  } abCtrl_t;

endpackage

// File: rtl/autobaud_dp.sv
module autobaud_dp
  import autobaud_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TMO_CYCLES = 1 << 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  abCtrl_t          ctrl,
  output logic             txLine,
  output logic [CNT_W-1:0] divisor,
  output logic             rxFall,
  output logic             rxEdge,
  output logic             finalEdge,
  output logic             measPass,
  output logic             frameDone,
  output logic             tmoHit
);

  localparam int TMO_W  = $clog2(TMO_CYCLES);
  localparam int SUM_W  = CNT_W + SPAN_SHIFT;
  localparam int EDGE_W = $clog2(SEG_COUNT);
  localparam int TOL_W  = CNT_W + 2;
  localparam int BIT_W  = $clog2(FRAME_BITS + 1);

  // ---------------- receive synchronizer and edge detect
  logic rxMeta, rxSync, rxPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end
  assign rxEdge = rxSync ^ rxPrev;
  assign rxFall = rxPrev & ~rxSync;

  // ---------------- segment timing
  logic [CNT_W-1:0]  segCnt, firstSeg, minOne, maxOne;
  logic [EDGE_W-1:0] edgeCnt;
  logic [SUM_W-1:0]  total;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segCnt   <= '0;
      edgeCnt  <= '0;
      total    <= '0;
      firstSeg <= '0;
      minOne   <= '1;
      maxOne   <= '0;
    end else begin
      if (ctrl.startMeas || ctrl.captureSeg) segCnt <= CNT_W'(1);
      else if (segCnt != '1)                 segCnt <= segCnt + 1'b1;

      if (ctrl.startMeas) begin
        edgeCnt <= '0;
        total   <= '0;
        minOne  <= '1;
        maxOne  <= '0;
      end else if (ctrl.captureSeg) begin
        edgeCnt <= edgeCnt + 1'b1;
        total   <= total + SUM_W'(segCnt);
        if (edgeCnt == '0) begin
          firstSeg <= segCnt;
        end else begin
          if (segCnt < minOne) minOne <= segCnt;
          if (segCnt > maxOne) maxOne <= segCnt;
        end
      end
    end
  end
  assign finalEdge = (edgeCnt == EDGE_W'(SEG_COUNT - 1));

  // ---------------- average and tolerance window
  logic [SUM_W-1:0] rounded;
  logic [CNT_W-1:0] avg;
  logic [TOL_W-1:0] avgX, quarterX, halfX, twoX;
  logic [TOL_W-1:0] oneLo, oneHi, twoLo, twoHi;

  always_comb begin
    rounded  = total + SUM_W'(1 << (SPAN_SHIFT - 1));
    avg      = CNT_W'(rounded >> SPAN_SHIFT);
    avgX     = TOL_W'(avg);
    quarterX = avgX >> 2;
    halfX    = avgX >> 1;
    twoX     = avgX << 1;
    oneLo    = avgX - quarterX;
    oneHi    = avgX + quarterX;
    twoLo    = twoX - halfX;
    twoHi    = twoX + halfX;
    measPass = (TOL_W'(minOne) >= oneLo) && (TOL_W'(maxOne) <= oneHi) &&
               (TOL_W'(firstSeg) >= twoLo) && (TOL_W'(firstSeg) <= twoHi);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             divisor <= '0;
    else if (ctrl.loadDiv) divisor <= avg;
  end

  // ---------------- acknowledge transmitter
  logic [FRAME_BITS-1:0] txShift;
  logic [CNT_W-1:0]      baudCnt;
  logic [BIT_W-1:0]      bitsLeft;
  logic [7:0]            ackByte;

  assign ackByte   = ctrl.byteSel ? ACK_SECOND : ACK_FIRST;
  assign frameDone = (bitsLeft == BIT_W'(1)) && (baudCnt == '0);
  assign txLine    = txShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '1;
      baudCnt  <= '0;
      bitsLeft <= '0;
    end else if (ctrl.loadByte) begin
      txShift  <= {1'b1, ackByte, 1'b0};
      baudCnt  <= divisor - 1'b1;
      bitsLeft <= BIT_W'(FRAME_BITS);
    end else if (bitsLeft != '0) begin
      if (baudCnt == '0) begin
        txShift  <= {1'b1, txShift[FRAME_BITS-1:1]};
        baudCnt  <= divisor - 1'b1;
        bitsLeft <= bitsLeft - 1'b1;
      end else begin
        baudCnt <= baudCnt - 1'b1;
      end
    end
  end

  // ---------------- silence timeout
  logic [TMO_W-1:0] tmoCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        tmoCnt <= '0;
    else if (!ctrl.tmoRun || rxEdge)  tmoCnt <= '0;
    else                              tmoCnt <= tmoCnt + 1'b1;
  end
  assign tmoHit = ctrl.tmoRun && !rxEdge && (tmoCnt == TMO_W'(TMO_CYCLES - 1));

  // R5: every frame opens with a low start bit
  p_frame_start_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadByte |=> !txLine);
  // R5: frame bit counter never exceeds one frame
  p_bits_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitsLeft <= BIT_W'(FRAME_BITS));

endmodule

// File: rtl/autobaud_ctrl.sv
module autobaud_ctrl
  import autobaud_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    rxFall,
  input  logic    rxEdge,
  input  logic    finalEdge,
  input  logic    measPass,
  input  logic    frameDone,
  input  logic    tmoHit,
  output abCtrl_t ctrl,
  output logic    locked,
  output logic    ready,
  output logic    timeout
);

  abState_t state;

  always_comb begin
    ctrl = '0;
    if (!start) begin
      ctrl.tmoRun     = (state == S_ARM) || (state == S_MEAS);
      ctrl.startMeas  = (state == S_ARM) && rxFall;
      ctrl.captureSeg = (state == S_MEAS) && rxEdge;
      ctrl.loadDiv    = (state == S_CHECK) && measPass;
      ctrl.loadByte   = (state == S_LOAD0) || ((state == S_TX0) && frameDone);
      ctrl.byteSel    = (state == S_TX0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      locked  <= 1'b0;
      ready   <= 1'b0;
      timeout <= 1'b0;
    end else if (start) begin
      state   <= S_ARM;
      locked  <= 1'b0;
      ready   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_ARM: begin
          if (tmoHit) begin
            state   <= S_IDLE;
            timeout <= 1'b1;
          end else if (rxFall) begin
            state <= S_MEAS;
          end
        end
        S_MEAS: begin
          if (tmoHit) begin
            state   <= S_IDLE;
            timeout <= 1'b1;
          end else if (rxEdge && finalEdge) begin
            state <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (measPass) begin
            state  <= S_LOAD0;
            locked <= 1'b1;
          end else begin
            state <= S_ARM;
          end
        end
        S_LOAD0: state <= S_TX0;
        S_TX0:   if (frameDone) state <= S_TX1;
        S_TX1: begin
          if (frameDone) begin
            state <= S_DONE;
            ready <= 1'b1;
          end
        end
        S_DONE: ;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: payload release only with a valid rate
  p_ready_needs_lock_r6: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> locked);
  // R7: a timed-out unit never reports lock
  p_lock_excludes_timeout_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(locked && timeout));
  // R8: start clears all status on the next edge
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!locked && !ready && !timeout));

endmodule

// File: rtl/autobaud_ack.sv
module autobaud_ack
  import autobaud_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TMO_CYCLES = 1 << 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             rxLine,
  output logic             txLine,
  output logic [CNT_W-1:0] divisor,
  output logic             locked,
  output logic             ready,
  output logic             timeout
);

  abCtrl_t ctrl;
  logic rxFall, rxEdge, finalEdge, measPass, frameDone, tmoHit;

  autobaud_dp #(.CNT_W(CNT_W), .TMO_CYCLES(TMO_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .ctrl(ctrl),
    .txLine(txLine), .divisor(divisor), .rxFall(rxFall), .rxEdge(rxEdge),
    .finalEdge(finalEdge), .measPass(measPass), .frameDone(frameDone),
    .tmoHit(tmoHit)
  );

  autobaud_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rxFall(rxFall), .rxEdge(rxEdge),
    .finalEdge(finalEdge), .measPass(measPass), .frameDone(frameDone),
    .tmoHit(tmoHit), .ctrl(ctrl), .locked(locked), .ready(ready),
    .timeout(timeout)
  );

  // R9: the measured rate is frozen while locked
  p_div_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked)) |-> $stable(divisor));

endmodule

// File: tb/tb_autobaud_ack.sv
module tb_autobaud_ack;
  localparam int CNT_W = 16;
  localparam int TMO   = 3000;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, rxLine = 1'b1;
  logic txLine, locked, ready, timeout;
  logic [CNT_W-1:0] divisor;

  always #4 clk = ~clk;

  autobaud_ack #(.CNT_W(CNT_W), .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rstN(rstN), .start(start), .rxLine(rxLine), .txLine(txLine),
    .divisor(divisor), .locked(locked), .ready(ready), .timeout(timeout)
  );

  int checks = 0, fails = 0;
  int curP = 40, gotBytes = 0, expBytes = 0, txHighRun = 0;
  logic [7:0] expQ[$];
  logic readyPrev = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic rxHold(input logic v, input int n);
    rxLine = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendUart(input logic [7:0] b, input int p);
    rxHold(1'b0, p);
    for (int i = 0; i < 8; i++) rxHold(b[i], p);
    rxHold(1'b1, p);
  endtask

  task automatic pulseStart;
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic expectAck(input int p);
    curP = p;
    expQ.push_back(8'h4F);
    expQ.push_back(8'h4B);
    expBytes += 2;
  endtask

  task automatic waitReady(input string req);
    int n = 0;
    while (!ready && n < 8000) begin
      @(posedge clk);
      #1 n++;
    end
    check(ready === 1'b1, req, "ready after acknowledge", int'(ready), 1);
  endtask

  // monitor side of the scoreboard: mid-bit sampling of txLine
  initial begin
    logic [7:0] got, e;
    logic okFrame;
    forever begin
      @(negedge txLine);
      repeat (curP / 2) @(negedge clk);
      okFrame = (txLine == 1'b0);
      for (int i = 0; i < 8; i++) begin
        repeat (curP) @(negedge clk);
        got[i] = txLine;
      end
      repeat (curP) @(negedge clk);
      okFrame = okFrame && txLine;
      check(okFrame, "R5", "start/stop bit levels", int'(okFrame), 1);
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected frame", int'(got), -1);
      end else begin
        e = expQ.pop_front();
        check(got == e, "R5", "acknowledge byte", int'(got), int'(e));
      end
      gotBytes++;
    end
  end

  // R6: ready edge against the end of the final stop bit
  always @(negedge clk) begin
    if (txLine === 1'b1) txHighRun++;
    else                 txHighRun = 0;
    if (ready === 1'b1 && readyPrev !== 1'b1) begin
      check(gotBytes == expBytes, "R6", "frames complete at ready", gotBytes, expBytes);
      check(txHighRun >= curP + 1, "R6", "stop bit length before ready", txHighRun, curP + 1);
    end
    readyPrev = ready;
  end

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish in time");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk);
    #1;
    // R1 reset state
    check(txLine == 1'b1, "R1", "txLine", int'(txLine), 1);
    check(locked == 1'b0, "R1", "locked", int'(locked), 0);
    check(ready == 1'b0, "R1", "ready", int'(ready), 0);
    check(timeout == 1'b0, "R1", "timeout", int'(timeout), 0);
    check(divisor == '0, "R1", "divisor", int'(divisor), 0);

    // R10: traffic before any start
    sendUart(8'hAA, 40);
    rxHold(1'b1, 50);
    check(locked == 1'b0, "R10", "no lock while idle", int'(locked), 0);
    check(gotBytes == 0, "R10", "no frames while idle", gotBytes, 0);

    // R2 / R5 / R6 / R9: clean sync at 40 clocks per bit, rx noise during ack
    pulseStart();
    expectAck(40);
    sendUart(8'hAA, 40);
    sendUart(8'h00, 17);
    waitReady("R6");
    check(divisor == 40, "R2", "divisor", int'(divisor), 40);
    check(locked == 1'b1, "R2", "locked", int'(locked), 1);
    sendUart(8'h0F, 23);
    rxHold(1'b1, 40);
    check(divisor == 40, "R9", "divisor held after lock", int'(divisor), 40);
    check(gotBytes == 2, "R9", "no extra frames", gotBytes, 2);

    // R8: start drops lock and ready
    pulseStart();
    check(locked == 1'b0, "R8", "locked cleared", int'(locked), 0);
    check(ready == 1'b0, "R8", "ready cleared", int'(ready), 0);

    // R7: silence while armed
    rxHold(1'b1, TMO + 100);
    check(timeout == 1'b1, "R7", "timeout while armed", int'(timeout), 1);
    check(locked == 1'b0, "R7", "no lock on timeout", int'(locked), 0);
    sendUart(8'hAA, 40);
    rxHold(1'b1, 100);
    check(locked == 1'b0, "R7", "traffic ignored after timeout", int'(locked), 0);
    check(gotBytes == 2, "R7", "no frames after timeout", gotBytes, 2);

    // R8: start clears timeout
    pulseStart();
    check(timeout == 1'b0, "R8", "timeout cleared", int'(timeout), 0);

    // R7: silence in the middle of a byte
    rxHold(1'b0, 40);
    rxHold(1'b1, 40);
    rxHold(1'b0, 40);
    rxHold(1'b1, TMO + 100);
    check(timeout == 1'b1, "R7", "timeout mid-measurement", int'(timeout), 1);
    check(locked == 1'b0, "R7", "no lock mid-measurement", int'(locked), 0);

    // R3: one stretched segment, then re-arm without start
    pulseStart();
    rxHold(1'b0, 80); rxHold(1'b1, 40); rxHold(1'b0, 60); rxHold(1'b1, 40);
    rxHold(1'b0, 40); rxHold(1'b1, 40); rxHold(1'b0, 40); rxHold(1'b1, 100);
    check(locked == 1'b0, "R3", "stretched segment rejected", int'(locked), 0);
    expectAck(24);
    sendUart(8'hAA, 24);
    waitReady("R3");
    check(divisor == 24, "R3", "divisor after re-arm", int'(divisor), 24);

    // R3: 0x55 has a one-bit first low segment
    pulseStart();
    sendUart(8'h55, 32);
    rxHold(1'b1, 100);
    check(locked == 1'b0, "R3", "0x55 rejected", int'(locked), 0);
    pulseStart();
    expectAck(32);
    sendUart(8'hAA, 32);
    waitReady("R3");
    check(divisor == 32, "R3", "divisor after 0x55", int'(divisor), 32);

    // R4: jittered segments average to the nominal period
    pulseStart();
    expectAck(48);
    rxHold(1'b0, 96); rxHold(1'b1, 54); rxHold(1'b0, 42); rxHold(1'b1, 48);
    rxHold(1'b0, 48); rxHold(1'b1, 48); rxHold(1'b0, 48); rxHold(1'b1, 200);
    waitReady("R4");
    check(divisor == 48, "R4", "averaged divisor", int'(divisor), 48);

    rxHold(1'b1, 50);
    check(expQ.size() == 0, "R5", "all expected bytes seen", expQ.size(), 0);
    summary();
    $finish;
  end
endmodule